// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

A 32-bit processor that completes one instruction per clock. It fetches a word from its own instruction memory at the program counter, decodes it, reads two register operands, runs them (or a base register and a sign-extended offset) through the ALU, optionally touches its data memory, and writes a result back into a 32-entry register file. The set it runs covers word load and store, register add, subtract, AND, OR, signed set-less-than, branch-if-equal and an absolute jump.

The register file commits on the falling clock edge, so a result is stored in the middle of the cycle that produced it, while the program counter and data memory update on the rising edge. A preload and observe port, meant only for test, writes either memory and reads back one register, one data-memory word and the program counter. The usual flow is to hold reset, preload program and data, release reset and let the core run.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low the program counter is 0, every register reads 0, and the core itself writes neither register file nor data memory; asserting rst_ni low clears the program counter at once.
- R2: The program counter stays word aligned and advances by 4 after every instruction other than a taken branch or a jump.
- R3: Instruction fields run MSB to LSB as opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], function [5:0]; opcode 0x00 with function 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt into rd.
- R4: Opcode 0x00 with function 0x2A writes 1 into rd when rs is less than rt as two's-complement numbers, else 0.
- R5: Opcode 0x23 (load) writes into rt the data-memory word at byte address rs + sign-extended bits [15:0]; the word index is address bits above bit 1.
- R6: Opcode 0x2B (store) writes rt into the data-memory word at rs + sign-extended bits [15:0] and leaves the register file unchanged.
- R7: Opcode 0x04 (branch-if-equal) sets the next address to PC+4 plus the sign-extended bits [15:0] shifted left by two when rs equals rt, else to PC+4; forward and backward offsets both work.
- R8: Opcode 0x02 (jump) sets the next address to the top four bits of PC+4, then bits [25:0] of the instruction, then two zero bits.
- R9: Register 0 always reads as 0; writes naming it are dropped.
- R10: Any other opcode, and opcode 0x00 with any other function code, changes no register and no memory word and advances the program counter by 4.
- R11: A register result is readable during the second half of the cycle that produced it, before the program counter moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; PC and memories on rising edge, register file on falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_we_i | input | 1 | Preload write strobe |
| ld_dmem_i | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr_i | input | 32 | Preload byte address |
| ld_wdata_i | input | 32 | Preload word |
| obs_reg_addr_i | input | 5 | Register number to observe |
| obs_reg_data_o | output | 32 | Value of the observed register |
| obs_mem_addr_i | input | 32 | Data-memory byte address to observe |
| obs_mem_data_o | output | 32 | Data-memory word at that address |
| pc_o | output | 32 | Current program counter |

## Verification
The program counter moves one rising edge after an instruction is current, data-memory stores land on that same rising edge, and register results land on the falling edge inside the instruction's own cycle. The bench therefore samples shortly after each falling edge, where it checks that the counter still shows the instruction just executed and that its register result is already visible; store results and the final state are read through the observe port after the program settles in a branch loop. Reset behaviour is checked both while held from the start and when asserted mid-run, one time step after the edge of rst_ni.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    wsel_rd;   // destination from rd, else rt
    logic    use_imm;
    logic    mem_rd;
    logic    mem_wr;
    logic    wb_mem;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (op_i)
      OP_RTYPE: begin
        ctrl_o.wsel_rd = 1'b1;
        ctrl_o.rf_we   = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.rf_we  = 1'b0;  // unsupported function: no-op
        endcase
      end
      OP_LW: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
      end
      OP_SW: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_J:    ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] y_o,
  output logic          zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(DW-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int NRP  = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NRP-1:0][AW-1:0]  ra_i,
  output logic [NRP-1:0][DW-1:0]  rd_o,
  input  logic                    we_i,
  input  logic [AW-1:0]           wa_i,
  input  logic [DW-1:0]           wd_i
);
  logic [DW-1:0] q [NREG];

  // mid-cycle commit; entry 0 is never written
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      q[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    assign rd_o[p] = q[ra_i[p]];
  end
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int DW    = 32,
  parameter int WORDS = 64,
  parameter int NRP   = 1,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           wa_i,
  input  logic [DW-1:0]           wd_i,
  input  logic [NRP-1:0][AW-1:0]  ra_i,
  output logic [NRP-1:0][DW-1:0]  rd_o
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    assign rd_o[p] = mem[ra_i[p]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ld_we_i,
  input  logic        ld_dmem_i,
  input  logic [31:0] ld_addr_i,
  input  logic [31:0] ld_wdata_i,
  input  logic [4:0]  obs_reg_addr_i,
  output logic [31:0] obs_reg_data_o,
  input  logic [31:0] obs_mem_addr_i,
  output logic [31:0] obs_mem_data_o,
  output logic [31:0] pc_o
);
  localparam int DW  = 32;
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int RAW = $clog2(NREG);

  logic [DW-1:0] pc_q, pc_next, pc_plus4, br_target, j_target;
  logic [DW-1:0] instr, imm_ext, rs_data, rt_data, alu_b, alu_y, wb_data;
  logic [DW-1:0] dmem_rdata;
  logic [RAW-1:0] rf_waddr;
  logic           alu_zero, core_mem_wr, rf_we;
  ctrl_t          ctrl;

  // fetch
  logic [0:0][IAW-1:0] imem_ra;
  logic [0:0][DW-1:0]  imem_rd;
  assign imem_ra[0] = pc_q[IAW+1:2];
  assign instr      = imem_rd[0];

  sc_mem #(.DW(DW), .WORDS(IMEM_WORDS), .NRP(1)) u_imem (
    .clk_i (clk_i),
    .we_i  (ld_we_i && !ld_dmem_i),
    .wa_i  (ld_addr_i[IAW+1:2]),
    .wd_i  (ld_wdata_i),
    .ra_i  (imem_ra),
    .rd_o  (imem_rd)
  );

  // decode
  sc_decode u_dec (
    .op_i    (instr[31:26]),
    .funct_i (instr[5:0]),
    .ctrl_o  (ctrl)
  );

  assign imm_ext  = {{(DW-16){instr[15]}}, instr[15:0]};
  assign rf_waddr = ctrl.wsel_rd ? instr[15:11] : instr[20:16];
  assign rf_we    = ctrl.rf_we && rst_ni;

  // registers: port 0 rs, 1 rt, 2 observe
  logic [2:0][RAW-1:0] rf_ra;
  logic [2:0][DW-1:0]  rf_rd;
  assign rf_ra = {obs_reg_addr_i, instr[20:16], instr[25:21]};
  assign rs_data        = rf_rd[0];
  assign rt_data        = rf_rd[1];
  assign obs_reg_data_o = rf_rd[2];

  sc_regfile #(.DW(DW), .NREG(NREG), .NRP(3)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (rf_ra),
    .rd_o   (rf_rd),
    .we_i   (rf_we),
    .wa_i   (rf_waddr),
    .wd_i   (wb_data)
  );

  // execute
  assign alu_b = ctrl.use_imm ? imm_ext : rt_data;

  sc_alu #(.DW(DW)) u_alu (
    .a_i    (rs_data),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // data memory: port 0 core load, port 1 observe; preload wins the write port
  logic [1:0][DAW-1:0] dmem_ra;
  logic [1:0][DW-1:0]  dmem_rd;
  logic                dmem_we;
  logic [DAW-1:0]      dmem_wa;
  logic [DW-1:0]       dmem_wd;
  logic                ld_dmem_we;

  assign core_mem_wr = ctrl.mem_wr && rst_ni;
  assign ld_dmem_we  = ld_we_i && ld_dmem_i;
  assign dmem_we     = ld_dmem_we || core_mem_wr;
  assign dmem_wa     = ld_dmem_we ? ld_addr_i[DAW+1:2] : alu_y[DAW+1:2];
  assign dmem_wd     = ld_dmem_we ? ld_wdata_i : rt_data;
  assign dmem_ra     = {obs_mem_addr_i[DAW+1:2], alu_y[DAW+1:2]};
  assign dmem_rdata     = ctrl.mem_rd ? dmem_rd[0] : '0;
  assign obs_mem_data_o = dmem_rd[1];

  sc_mem #(.DW(DW), .WORDS(DMEM_WORDS), .NRP(2)) u_dmem (
    .clk_i (clk_i),
    .we_i  (dmem_we),
    .wa_i  (dmem_wa),
    .wd_i  (dmem_wd),
    .ra_i  (dmem_ra),
    .rd_o  (dmem_rd)
  );

  assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;

  // next address
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[DW-3:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                    pc_next = j_target;
    else if (ctrl.branch && alu_zero) pc_next = br_target;
    else                              pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  logic unused_bits;
  assign unused_bits = ^{ld_addr_i, obs_mem_addr_i, alu_y, pc_q, instr[10:6]};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_core_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input logic [31:0] rs_data_i,
  input logic [31:0] rt_data_i,
  input logic        rf_we_i,
  input logic        mem_wr_i,
  input logic [4:0]  obs_reg_addr_i,
  input logic [31:0] obs_reg_data_i
);
  logic [5:0]  op;
  logic [31:0] off4;
  logic        op_known;
  assign op       = instr_i[31:26];
  assign off4     = {{14{instr_i[15]}}, instr_i[15:0], 2'b00};
  assign op_known = (op == OP_RTYPE) || (op == OP_LW) || (op == OP_SW) ||
                    (op == OP_BEQ) || (op == OP_J);

  AST_PC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[1:0] == 2'b00);  // R2

  AST_SEQ_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ && op != OP_J) |=> pc_i == $past(pc_i) + 32'd4);  // R2

  AST_BEQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && rs_data_i == rt_data_i) |=>
    pc_i == $past(pc_i) + 32'd4 + $past(off4));  // R7

  AST_BEQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && rs_data_i != rt_data_i) |=> pc_i == $past(pc_i) + 32'd4);  // R7

  AST_JUMP_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_J) |=>
    pc_i == {$past(pc_i[31:28] + {3'b000, &pc_i[27:2]}), $past(instr_i[25:0]), 2'b00});  // R8

  AST_R0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obs_reg_addr_i == 5'd0) |-> obs_reg_data_i == 32'd0);  // R9

  AST_STORE_NO_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |-> !rf_we_i);  // R6

  AST_UNSUP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_known |-> (!rf_we_i && !mem_wr_i));  // R10
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pc_i           (pc_q),
  .instr_i        (instr),
  .rs_data_i      (rs_data),
  .rt_data_i      (rt_data),
  .rf_we_i        (rf_we),
  .mem_wr_i       (core_mem_wr),
  .obs_reg_addr_i (obs_reg_addr_i),
  .obs_reg_data_i (obs_reg_data_o)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_we_i = 1'b0, ld_dmem_i = 1'b0;
  logic [31:0] ld_addr_i = '0, ld_wdata_i = '0;
  logic [4:0]  obs_reg_addr_i = '0;
  logic [31:0] obs_reg_data_o, obs_mem_addr_i = '0, obs_mem_data_o, pc_o;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sc_core dut (.*);

  function automatic logic [31:0] r_t(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_t(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  localparam int NPROG = 24;
  localparam logic [31:0] PROG [NPROG] = '{
    i_t(6'h23, 0, 1, 16'd0),        // 00 lw r1,0(r0)
    i_t(6'h23, 0, 2, 16'd4),        // 04 lw r2,4(r0)
    i_t(6'h23, 0, 3, 16'd8),        // 08 lw r3,8(r0)
    r_t(1, 3, 4, 6'h20),            // 0C add r4
    r_t(1, 3, 5, 6'h22),            // 10 sub r5
    r_t(3, 1, 6, 6'h24),            // 14 and r6
    r_t(3, 1, 7, 6'h25),            // 18 or r7
    r_t(2, 1, 8, 6'h2A),            // 1C slt r8 = r2<r1
    r_t(1, 2, 9, 6'h2A),            // 20 slt r9 = r1<r2
    i_t(6'h2B, 0, 4, 16'd16),       // 24 sw r4,16(r0)
    i_t(6'h23, 3, 10, 16'hFFFC),    // 28 lw r10,-4(r3)
    r_t(1, 1, 0, 6'h20),            // 2C add r0 (dropped)
    i_t(6'h04, 1, 2, 16'd5),        // 30 beq not taken
    i_t(6'h04, 3, 10, 16'd2),       // 34 beq taken -> 40
    r_t(1, 1, 11, 6'h20),           // 38 skipped
    r_t(1, 1, 11, 6'h20),           // 3C skipped
    32'hFC0C_FFFF,                  // 40 unknown opcode
    r_t(1, 1, 13, 6'h00),           // 44 unknown function
    {6'h02, 26'h16},                // 48 j 0x58
    r_t(1, 1, 14, 6'h20),           // 4C skipped
    r_t(1, 1, 14, 6'h20),           // 50 skipped
    r_t(1, 1, 14, 6'h20),           // 54 skipped
    i_t(6'h04, 0, 0, 16'hFFFF),     // 58 beq to self
    r_t(1, 1, 14, 6'h20)            // 5C never reached
  };

  typedef struct packed {
    logic [31:0] pc;
    logic [4:0]  rg;
    logic [31:0] val;
    logic [3:0]  tag;
  } step_t;

  localparam int NSTEP = 20;
  localparam step_t TRACE [NSTEP] = '{
    '{32'h00, 5'd1,  32'd5,         4'd5},   // R5 R11
    '{32'h04, 5'd2,  32'hFFFFFFFD,  4'd5},   // R5
    '{32'h08, 5'd3,  32'd12,        4'd5},   // R5
    '{32'h0C, 5'd4,  32'd17,        4'd3},   // R3 add
    '{32'h10, 5'd5,  32'hFFFFFFF9,  4'd3},   // R3 sub
    '{32'h14, 5'd6,  32'd4,         4'd3},   // R3 and
    '{32'h18, 5'd7,  32'd13,        4'd3},   // R3 or
    '{32'h1C, 5'd8,  32'd1,         4'd4},   // R4 signed true
    '{32'h20, 5'd9,  32'd0,         4'd4},   // R4 signed false
    '{32'h24, 5'd4,  32'd17,        4'd6},   // R6 store keeps regs
    '{32'h28, 5'd10, 32'd12,        4'd5},   // R5 negative offset
    '{32'h2C, 5'd0,  32'd0,         4'd9},   // R9
    '{32'h30, 5'd1,  32'd5,         4'd7},   // R7 not taken
    '{32'h34, 5'd10, 32'd12,        4'd7},   // R7 taken next
    '{32'h40, 5'd12, 32'd0,         4'd10},  // R10 unknown opcode
    '{32'h44, 5'd13, 32'd0,         4'd10},  // R10 unknown function
    '{32'h48, 5'd14, 32'd0,         4'd8},   // R8
    '{32'h58, 5'd11, 32'd0,         4'd8},   // R8 target, R7 skip
    '{32'h58, 5'd14, 32'd0,         4'd7},   // R7 backward
    '{32'h58, 5'd2,  32'hFFFFFFFD,  4'd2}    // R2
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic preload(logic to_dmem, logic [31:0] addr, logic [31:0] data);
    @(negedge clk_i);
    ld_we_i = 1'b1; ld_dmem_i = to_dmem; ld_addr_i = addr; ld_wdata_i = data;
    @(negedge clk_i);
    ld_we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < NPROG; i++) preload(1'b0, 32'(i * 4), PROG[i]);
    preload(1'b1, 32'd0,  32'd5);
    preload(1'b1, 32'd4,  32'hFFFFFFFD);
    preload(1'b1, 32'd8,  32'd12);
    preload(1'b1, 32'd12, 32'h0F0F00FF);
    preload(1'b1, 32'd16, 32'hDEADBEEF);

    // R1: state held in reset
    @(negedge clk_i); obs_reg_addr_i = 5'd1; #1;
    check("R1", pc_o, 32'd0);
    check("R1", obs_reg_data_o, 32'd0);

    @(posedge clk_i); #2 rst_ni = 1'b1;

    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk_i);
      obs_reg_addr_i = TRACE[s].rg;
      #1;
      check($sformatf("R%0d pc", TRACE[s].tag), pc_o, TRACE[s].pc);
      check($sformatf("R%0d reg", TRACE[s].tag), obs_reg_data_o, TRACE[s].val);
    end

    // R6: stored word and neighbours
    obs_mem_addr_i = 32'd16; #1;
    check("R6", obs_mem_data_o, 32'd17);
    obs_mem_addr_i = 32'd12; #1;
    check("R6", obs_mem_data_o, 32'h0F0F00FF);
    // R10: unknown opcode left memory alone
    obs_mem_addr_i = 32'd0; #1;
    check("R10", obs_mem_data_o, 32'd5);
    // R9
    obs_reg_addr_i = 5'd0; #1;
    check("R9", obs_reg_data_o, 32'd0);
    // R7: still parked in the loop
    repeat (4) @(negedge clk_i); #1;
    check("R7", pc_o, 32'h58);

    // R1: asynchronous reset mid-run
    @(posedge clk_i); #2 rst_ni = 1'b0; #1;
    check("R1", pc_o, 32'd0);
    @(negedge clk_i); obs_reg_addr_i = 5'd4; #1;
    check("R1", obs_reg_data_o, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_run++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule